// File: doc/BRIEF.md
# Microcontroller Power-Mode Controller

This block holds the power-control register of an 8-bit microcontroller core and turns it into two enables: one that lets the core fetch and execute instructions, and one that keeps the peripheral and timer clock running. Software sets a mode bit over a simple special-function-register write port. Setting the idle bit stops instruction fetch while the timers keep counting. Setting the power-down bit stops both. The register also holds two general-purpose flag bits, which software may use freely.

Pending interrupt requests that are also enabled wake the core. The controller evaluates them only on the machine-cycle sample strobe. Any enabled request ends idle. Power-down ends only when the enabled request comes from one of the two external interrupt inputs. When both mode bits are set, power-down decides the behaviour. A build parameter turns the low-power function off. With it off, the register still stores and returns its bits, but the enables stay asserted and no wake-up clearing takes place.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The register's fields are: bit 0 idle request, bit 1 power-down request, bit 2 flag A, bit 3 flag B. A write with `sfr_sel` and `sfr_we` high stores `sfr_wdata[3:0]` at the clock edge. `sfr_rdata` returns those four bits in the same positions, and bits 7..4 always read 0.
- R2: A clock edge with `rst` high clears the whole register to 0 and drives `core_run` and `periph_clk_en` to 1.
- R3: While the idle bit is 1 and the power-down bit is 0, `core_run` is 0 and `periph_clk_en` is 1. The outputs reflect the register contents one clock after those contents change.
- R4: While the power-down bit is 1, both `core_run` and `periph_clk_en` are 0, whatever the idle bit holds.
- R5: On a clock edge with `tick` high, a pending request (`irq_pend` bit 1) whose enable (`irq_en` bit 1) is also 1 clears the idle bit. Any source can do this.
- R6: On a clock edge with `tick` high, the power-down bit clears only when the enabled pending set includes source `EXT0_IDX` (default 0) or source `EXT1_IDX` (default 2). Requests from other sources leave the power-down bit set.
- R7: Pending requests have no effect on the register on clock edges where `tick` is 0.
- R8: A pending request whose enable bit is 0 clears no bit.
- R9: When a register write and a wake-up clear fall on the same edge, the register takes the written value.
- R10: With `LOWPWR_EN` = 0, `core_run` and `periph_clk_en` stay 1, and the register keeps its written mode bits when enabled requests arrive with `tick` high.
- R11: The flag bits are never changed by a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_sel | input | 1 | Register is addressed |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | DATA_W | Write data |
| sfr_rdata | output | DATA_W | Register contents, upper bits zero |
| tick | input | 1 | Machine-cycle interrupt sample strobe |
| irq_pend | input | IRQ_NUM | Pending interrupt requests, one bit per source |
| irq_en | input | IRQ_NUM | Interrupt enables, one bit per source |
| core_run | output | 1 | Core instruction execution enable (registered) |
| periph_clk_en | output | 1 | Peripheral and timer clock enable (registered) |

## Verification
The bench enters idle and then raises each interrupt source alone. This shows that every source can end idle. It repeats the test in power-down, where only the two external positions may restart the clock. Requests that are pending but disabled, and requests that arrive without the sample strobe, must leave the register unchanged. These cases separate the gating terms of the wake-up logic. With both mode bits set, a non-external wake shows that power-down takes precedence. A write on the same edge as a wake shows the write priority. A second instance with the low-power function off receives the same stimulus and must keep both enables high.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int PCR_W   = 4;
  localparam int BIT_IDL = 0;
  localparam int BIT_PD  = 1;
  localparam int BIT_GFA = 2;
  localparam int BIT_GFB = 3;

  typedef struct packed {
    logic flag_b;
    logic flag_a;
    logic pdown;
    logic idle;
  } pcr_t;
endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int IRQ_NUM   = 5,
  parameter int EXT0_IDX  = 0,
  parameter int EXT1_IDX  = 2,
  parameter bit LOWPWR_EN = 1'b1
) (
  input  logic               tick,
  input  logic [IRQ_NUM-1:0] irq_pend,
  input  logic [IRQ_NUM-1:0] irq_en,
  output logic               clr_idle,
  output logic               clr_pd
);
  logic [IRQ_NUM-1:0] live;
  assign live = irq_pend & irq_en;

  generate
    if (LOWPWR_EN) begin : g_lp
      assign clr_idle = tick & (|live);
      assign clr_pd   = tick & (live[EXT0_IDX] | live[EXT1_IDX]);
    end else begin : g_plain
      assign clr_idle = 1'b0;
      assign clr_pd   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pmc_reg.sv
module pmc_reg
  import pwr_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  pcr_t wr_data,
  input  logic clr_idle,
  input  logic clr_pd,
  output pcr_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data;
    end else begin
      if (clr_idle) q.idle  <= 1'b0;
      if (clr_pd)   q.pdown <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_out.sv
module pmc_out
  import pwr_mode_pkg::*;
#(
  parameter bit LOWPWR_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  pcr_t state,
  output logic core_run,
  output logic periph_clk_en
);
  logic idle_eff;
  logic run_d;
  logic per_d;

  generate
    if (LOWPWR_EN) begin : g_lp
      assign idle_eff = state.idle & ~state.pdown;
      assign run_d    = ~(state.pdown | idle_eff);
      assign per_d    = ~state.pdown;
    end else begin : g_plain
      assign idle_eff = 1'b0;
      assign run_d    = 1'b1;
      assign per_d    = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run      <= 1'b1;
      periph_clk_en <= 1'b1;
    end else begin
      core_run      <= run_d;
      periph_clk_en <= per_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IRQ_NUM   = 5,
  parameter int EXT0_IDX  = 0,
  parameter int EXT1_IDX  = 2,
  parameter bit LOWPWR_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sfr_sel,
  input  logic               sfr_we,
  input  logic [DATA_W-1:0]  sfr_wdata,
  output logic [DATA_W-1:0]  sfr_rdata,
  input  logic               tick,
  input  logic [IRQ_NUM-1:0] irq_pend,
  input  logic [IRQ_NUM-1:0] irq_en,
  output logic               core_run,
  output logic               periph_clk_en
);
  localparam int PAD_W = DATA_W - PCR_W;

  pcr_t reg_q;
  pcr_t wr_val;
  logic wr_en;
  logic clr_idle;
  logic clr_pd;

  assign wr_en  = sfr_sel & sfr_we;
  assign wr_val = pcr_t'(sfr_wdata[PCR_W-1:0]);

  pmc_wake #(
    .IRQ_NUM(IRQ_NUM), .EXT0_IDX(EXT0_IDX),
    .EXT1_IDX(EXT1_IDX), .LOWPWR_EN(LOWPWR_EN)
  ) u_wake (
    .tick(tick), .irq_pend(irq_pend), .irq_en(irq_en),
    .clr_idle(clr_idle), .clr_pd(clr_pd)
  );

  pmc_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_val),
    .clr_idle(clr_idle), .clr_pd(clr_pd), .q(reg_q)
  );

  pmc_out #(.LOWPWR_EN(LOWPWR_EN)) u_out (
    .clk(clk), .rst(rst), .state(reg_q),
    .core_run(core_run), .periph_clk_en(periph_clk_en)
  );

  assign sfr_rdata = {{PAD_W{1'b0}}, reg_q};
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int IRQ_NUM   = 5,
  parameter int EXT0_IDX  = 0,
  parameter int EXT1_IDX  = 2,
  parameter bit LOWPWR_EN = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               sfr_sel,
  input logic               sfr_we,
  input logic [DATA_W-1:0]  sfr_wdata,
  input logic [DATA_W-1:0]  sfr_rdata,
  input logic               tick,
  input logic [IRQ_NUM-1:0] irq_pend,
  input logic [IRQ_NUM-1:0] irq_en,
  input logic               core_run,
  input logic               periph_clk_en
);
  logic wr;
  logic any_live;
  logic ext_live;
  assign wr       = sfr_sel & sfr_we;
  assign any_live = |(irq_pend & irq_en);
  assign ext_live = irq_pend[EXT0_IDX] & irq_en[EXT0_IDX]
                  | irq_pend[EXT1_IDX] & irq_en[EXT1_IDX];

  p_reset_r2: assert property (@(posedge clk)
    rst |=> (sfr_rdata == '0) && core_run && periph_clk_en);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    sfr_rdata[DATA_W-1:4] == '0);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr |=> sfr_rdata[3:0] == $past(sfr_wdata[3:0]));

  p_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !tick && !wr |=> $stable(sfr_rdata));

  p_flags_kept_r11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(sfr_rdata[3:2]));

  generate
    if (LOWPWR_EN) begin : g_lp
      p_idle_out_r3: assert property (@(posedge clk) disable iff (rst)
        sfr_rdata[0] && !sfr_rdata[1] |=> !core_run && periph_clk_en);
      p_pd_out_r4: assert property (@(posedge clk) disable iff (rst)
        sfr_rdata[1] |=> !core_run && !periph_clk_en);
      p_wake_idle_r5: assert property (@(posedge clk) disable iff (rst)
        tick && any_live && !wr |=> !sfr_rdata[0]);
      p_pd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        sfr_rdata[1] && !(tick && ext_live) && !wr |=> sfr_rdata[1]);
    end else begin : g_plain
      p_plain_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> core_run && periph_clk_en);
    end
  endgenerate
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .DATA_W(DATA_W), .IRQ_NUM(IRQ_NUM), .EXT0_IDX(EXT0_IDX),
  .EXT1_IDX(EXT1_IDX), .LOWPWR_EN(LOWPWR_EN)
) u_chk (.*);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int DW = 8;
  localparam int NI = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sfr_sel = 1'b0;
  logic          sfr_we = 1'b0;
  logic [DW-1:0] sfr_wdata = '0;
  logic          tick = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NI-1:0] irq_en = '0;
  logic [DW-1:0] rdata, rdata_p;
  logic          run, per, run_p, per_p;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.DATA_W(DW), .IRQ_NUM(NI)) i_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(rdata), .tick(tick),
    .irq_pend(irq_pend), .irq_en(irq_en),
    .core_run(run), .periph_clk_en(per));

  pwr_mode_ctrl #(.DATA_W(DW), .IRQ_NUM(NI), .LOWPWR_EN(1'b0)) i_pwr_mode_ctrl_plain (
    .clk(clk), .rst(rst), .sfr_sel(sfr_sel), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(rdata_p), .tick(tick),
    .irq_pend(irq_pend), .irq_en(irq_en),
    .core_run(run_p), .periph_clk_en(per_p));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  // write, then register visible after one edge
  task automatic wr(input logic [DW-1:0] d);
    sfr_sel = 1'b1; sfr_we = 1'b1; sfr_wdata = d;
    step();
    sfr_sel = 1'b0; sfr_we = 1'b0; sfr_wdata = '0;
  endtask

  task automatic wake(input logic [NI-1:0] p, input logic [NI-1:0] e, input logic t);
    irq_pend = p; irq_en = e; tick = t;
    step();
    irq_pend = '0; irq_en = '0; tick = 1'b0;
  endtask

  task automatic t_reset();
    wr(8'h0F); step();
    do_reset(); step();
    chk("R2 reg", rdata, 8'h00);
    chk("R2 run", run, 1'b1);
    chk("R2 per", per, 1'b1);
  endtask

  task automatic t_readback();
    wr(8'hF4); chk("R1 upper zero / flag A", rdata, 8'h04);
    wr(8'h08); chk("R1 flag B", rdata, 8'h08);
    wr(8'h0C); chk("R1 both flags", rdata, 8'h0C);
    sfr_sel = 1'b0; sfr_we = 1'b1; sfr_wdata = 8'h00; step(); sfr_we = 1'b0;
    chk("R1 unselected write ignored", rdata, 8'h0C);
    wr(8'h00);
  endtask

  task automatic t_idle_each_source();
    for (int s = 0; s < NI; s++) begin
      wr(8'h01); step();
      chk("R3 idle run", run, 1'b0);
      chk("R3 idle per", per, 1'b1);
      wake(NI'(1) << s, NI'(1) << s, 1'b1);
      chk("R5 idle cleared", rdata, 8'h00);
      step();
      chk("R5 run restored", run, 1'b1);
    end
  endtask

  task automatic t_pd_ext_only();
    for (int s = 0; s < NI; s++) begin
      wr(8'h0A); step();
      chk("R4 pd run", run, 1'b0);
      chk("R4 pd per", per, 1'b0);
      wake(NI'(1) << s, NI'(1) << s, 1'b1);
      if (s == 0 || s == 2) begin
        chk("R6 ext clears pd", rdata, 8'h08);
        step(); chk("R6 per restored", per, 1'b1);
      end else begin
        chk("R6 non-ext keeps pd", rdata, 8'h0A);
        step(); chk("R6 per still off", per, 1'b0);
      end
    end
    wr(8'h00);
  endtask

  task automatic t_precedence();
    wr(8'h03); step();
    chk("R4 both set run", run, 1'b0);
    chk("R4 both set per", per, 1'b0);
    wake(5'b00010, 5'b00010, 1'b1);
    chk("R6 non-ext clears idle only", rdata, 8'h02);
    wake(5'b00100, 5'b00100, 1'b1);
    chk("R6 ext1 clears pd", rdata, 8'h00);
  endtask

  task automatic t_gating();
    wr(8'h03);
    wake(5'b11111, 5'b11111, 1'b0);
    chk("R7 no tick no clear", rdata, 8'h03);
    wake(5'b11111, 5'b00000, 1'b1);
    chk("R8 disabled no clear", rdata, 8'h03);
    wake(5'b00101, 5'b11010, 1'b1);
    chk("R8 mismatched enable no clear", rdata, 8'h03);
    wr(8'h00);
  endtask

  task automatic t_write_wins();
    sfr_sel = 1'b1; sfr_we = 1'b1; sfr_wdata = 8'h07;
    irq_pend = 5'b11111; irq_en = 5'b11111; tick = 1'b1;
    step();
    sfr_sel = 1'b0; sfr_we = 1'b0; irq_pend = '0; irq_en = '0; tick = 1'b0;
    chk("R9 write wins", rdata, 8'h07);
    wake(5'b00001, 5'b00001, 1'b1);
    chk("R9 cleared at next sample, R11 flags kept", rdata, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_plain();
    wr(8'h0B); step();
    chk("R10 plain run", run_p, 1'b1);
    chk("R10 plain per", per_p, 1'b1);
    wake(5'b11111, 5'b11111, 1'b1);
    chk("R10 plain reg kept", rdata_p, 8'h0B);
    chk("R11 lowpower flags kept", rdata, 8'h08);
    wr(8'h00);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    step();
    do_reset(); step();
    t_reset();
    t_readback();
    t_idle_each_source();
    t_pd_ext_only();
    t_precedence();
    t_gating();
    t_write_wins();
    t_plain();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end
endmodule